// File: doc/BRIEF.md
# Event Fragment Merge Consistency Checker

This block sits at the point where event fragments from several sources are merged into one event block. For every event, each source presents the header of its fragment on a valid/ready stream. A header carries a bunch identifier and an event identifier.

The block takes one header from every source in the same cycle. It compares each source's identifiers with those of source 0 and emits a single merged header record. The record carries a corrupted tag and a one-hot mask of the sources that disagreed. The event is always forwarded, even when it is corrupted, and the fragments are never realigned.

The block also handles status for the merge point:
- **Broadcast check.** A broadcast readout-type message carries the two low bits of an event identifier. The block checks those bits against the local event identifier.
- **Overflow monitoring.** The block watches the overflow lines of the local buffers.
- **Per-event errors.** These are counted in saturating counters.
- **Fatal errors.** Loss of synchronisation and buffer overflow raise sticky flags that only the reset clears.

On the header inputs, a source's valid may rise at any time and is not required to wait for ready. Each source's header is consumed only in a cycle where its ready and valid are both high. On the output, the record is held stable until out_ready is seen high. While the output stage is full and out_ready is low, no header is consumed, so back-pressure passes straight to every source.

Top module: `evt_merge_check`

## Requirements
- R1: All hdr_ready bits are equal. They are high in a cycle exactly when every hdr_valid bit is high and the output stage is empty or out_ready is high. One header is then taken from every source in that cycle.
- R2: After an accepting clock edge, out_valid is high. out_bx and out_ev then carry the identifiers of source 0. While out_valid is high and out_ready is low, every output field stays unchanged. out_valid falls after an edge where out_ready was high and nothing was accepted.
- R3: Bit i of out_mask is 1 exactly when source i's bunch identifier or event identifier differs from source 0's. Source 0's own bit (bit 0) is always 0.
- R4: out_corrupt is 1 if any of the following holds, and the event is still forwarded either way:
  - the event's mask is nonzero;
  - stat_oos was already set when the event was accepted;
  - any stat_ovf bit was already set when the event was accepted.
- R5: stat_oos is set by the first accepted event with a nonzero mask. It stays set until reset. Later headers are still consumed as presented, with no attempt to realign them.
- R6: cnt_idmis rises by one for each accepted event with a nonzero mask. It holds at all ones instead of wrapping.
- R7: In a cycle with rot_valid high, rot_lsb is compared with the two low bits of a reference event identifier, and a difference raises cnt_rot by one, saturating. The reference is chosen as follows:
  - the event accepted in that same cycle, if there is one;
  - otherwise the most recently accepted event;
  - 0 if no event has been accepted since reset.
- R8: A high ovf_in bit sets the matching stat_ovf bit at the next clock edge. That bit stays set until reset.
- R9: When rst_n is low, the following are cleared: out_valid, out_corrupt, out_mask, stat_oos, stat_ovf, both counters, and the reference event identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low front-end reset |
| hdr_valid | input | NSRC | Per-source header valid |
| hdr_ready | output | NSRC | Per-source header ready (all bits equal) |
| hdr_bx | input | NSRC*BXW | Bunch identifiers, source i at bits [i*BXW +: BXW] |
| hdr_ev | input | NSRC*EVW | Event identifiers, source i at bits [i*EVW +: EVW] |
| out_valid | output | 1 | Merged header record valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_bx | output | BXW | Bunch identifier of source 0 |
| out_ev | output | EVW | Event identifier of source 0 |
| out_corrupt | output | 1 | Corrupted tag of the record |
| out_mask | output | NSRC | One-hot-per-source mask of disagreeing sources |
| rot_valid | input | 1 | Broadcast readout-type message present |
| rot_lsb | input | 2 | Two low event-identifier bits of the broadcast |
| ovf_in | input | OVFN | Local buffer overflow indications |
| stat_ovf | output | OVFN | Sticky overflow flags (fatal) |
| stat_oos | output | 1 | Sticky out-of-sync flag (fatal) |
| cnt_idmis | output | CNTW | Saturating count of events with identifier mismatch |
| cnt_rot | output | CNTW | Saturating count of broadcast event-number mismatches |

## Verification
The bench builds the block with the following parameters:
- **NSRC = 3.** This keeps both a middle source and the last source in the mask under test.
- **OVFN = 2.** This lets independent overflow flags be seen latching separately.
- **CNTW = 4.** A few hundred error-laden events then drive both counters far past their ceiling of 15, so saturation is exercised rather than assumed.

The identifier widths stay at 12 and 24 bits, so single-bit disagreements can be injected at the top bit of either field.

// File: rtl/emc_pkg.sv
package emc_pkg;
  // Width of the event-number fragment carried by the readout-type broadcast.
  localparam int ROT_W = 2;
  typedef logic [ROT_W-1:0] rot_lsb_t;

  // Merged record held in the output stage.
  typedef struct packed {
    logic corrupt;
    logic valid;
  } rec_flags_t;
endpackage

// File: rtl/emc_compare.sv
// Flags every source whose identifiers differ from the source 0 reference.
module emc_compare #(
  parameter int NSRC = 4,
  parameter int BXW  = 12,
  parameter int EVW  = 24
) (
  input  logic [NSRC*BXW-1:0] bx_flat,
  input  logic [NSRC*EVW-1:0] ev_flat,
  output logic [NSRC-1:0]     diff_mask
);
  logic [BXW-1:0] ref_bx;
  logic [EVW-1:0] ref_ev;

  assign ref_bx = bx_flat[BXW-1:0];
  assign ref_ev = ev_flat[EVW-1:0];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_ref
      assign diff_mask[i] = 1'b0;
    end else begin : g_cmp
      logic bx_ne, ev_ne;
      assign bx_ne = (bx_flat[i*BXW +: BXW] != ref_bx);
      assign ev_ne = (ev_flat[i*EVW +: EVW] != ref_ev);
      assign diff_mask[i] = bx_ne | ev_ne;
    end
  end
endmodule

// File: rtl/emc_sat_counter.sv
// Counter that stops at all ones instead of wrapping.
module emc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (inc && (count != TOP))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/emc_sticky.sv
// Bank of set-only flags, cleared by reset alone.
module emc_sticky #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag[i] <= 1'b0;
      else if (set[i])
        flag[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_merge_check.sv
module evt_merge_check #(
  parameter int NSRC = 4,
  parameter int BXW  = 12,
  parameter int EVW  = 24,
  parameter int OVFN = 4,
  parameter int CNTW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        hdr_valid,
  output logic [NSRC-1:0]        hdr_ready,
  input  logic [NSRC*BXW-1:0]    hdr_bx,
  input  logic [NSRC*EVW-1:0]    hdr_ev,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [BXW-1:0]         out_bx,
  output logic [EVW-1:0]         out_ev,
  output logic                   out_corrupt,
  output logic [NSRC-1:0]        out_mask,
  input  logic                   rot_valid,
  input  logic [emc_pkg::ROT_W-1:0] rot_lsb,
  input  logic [OVFN-1:0]        ovf_in,
  output logic [OVFN-1:0]        stat_ovf,
  output logic                   stat_oos,
  output logic [CNTW-1:0]        cnt_idmis,
  output logic [CNTW-1:0]        cnt_rot
);
  import emc_pkg::*;

  // ---------------- acceptance (R1) ----------------
  logic all_present, stage_free, accept;
  assign all_present = &hdr_valid;
  assign stage_free  = !out_valid || out_ready;
  assign accept      = all_present && stage_free;
  assign hdr_ready   = {NSRC{accept}};

  // ---------------- comparison (R3) ----------------
  logic [NSRC-1:0] diff_mask;
  logic            disagree;

  emc_compare #(.NSRC(NSRC), .BXW(BXW), .EVW(EVW)) u_cmp (
    .bx_flat   (hdr_bx),
    .ev_flat   (hdr_ev),
    .diff_mask (diff_mask)
  );
  assign disagree = |diff_mask;

  // ---------------- fatal flags (R5, R8) ----------------
  logic [0:0] oos_set, oos_flag;
  assign oos_set = accept && disagree;

  emc_sticky #(.N(1)) u_oos (
    .clk (clk), .rst_n (rst_n), .set (oos_set), .flag (oos_flag)
  );
  assign stat_oos = oos_flag[0];

  emc_sticky #(.N(OVFN)) u_ovf (
    .clk (clk), .rst_n (rst_n), .set (ovf_in), .flag (stat_ovf)
  );

  // ---------------- output stage (R2, R4) ----------------
  rec_flags_t rec;
  logic       tag_now;
  assign tag_now = disagree || stat_oos || (|stat_ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec      <= '0;
      out_bx   <= '0;
      out_ev   <= '0;
      out_mask <= '0;
    end else if (accept) begin
      rec.valid   <= 1'b1;
      rec.corrupt <= tag_now;
      out_bx      <= hdr_bx[BXW-1:0];
      out_ev      <= hdr_ev[EVW-1:0];
      out_mask    <= diff_mask;
    end else if (out_ready) begin
      rec.valid   <= 1'b0;
    end
  end
  assign out_valid   = rec.valid;
  assign out_corrupt = rec.corrupt;

  // ---------------- broadcast event-number check (R7) ----------------
  rot_lsb_t last_lsb, ref_lsb;
  logic     rot_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_lsb <= '0;
    else if (accept)
      last_lsb <= hdr_ev[ROT_W-1:0];
  end
  assign ref_lsb = accept ? hdr_ev[ROT_W-1:0] : last_lsb;
  assign rot_bad = rot_valid && (rot_lsb != ref_lsb);

  // ---------------- per-event error counters (R6, R7) ----------------
  logic [1:0] cnt_inc;
  logic [1:0][CNTW-1:0] cnt_val;
  assign cnt_inc = {rot_bad, accept && disagree};

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    emc_sat_counter #(.W(CNTW)) u_cnt (
      .clk (clk), .rst_n (rst_n), .inc (cnt_inc[k]), .count (cnt_val[k])
    );
  end
  assign cnt_idmis = cnt_val[0];
  assign cnt_rot   = cnt_val[1];
endmodule

// File: rtl/emc_checker.sv
module emc_checker #(
  parameter int NSRC = 4,
  parameter int BXW  = 12,
  parameter int EVW  = 24,
  parameter int OVFN = 4,
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] hdr_valid,
  input logic [NSRC-1:0] hdr_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [BXW-1:0]  out_bx,
  input logic [EVW-1:0]  out_ev,
  input logic            out_corrupt,
  input logic [NSRC-1:0] out_mask,
  input logic [OVFN-1:0] ovf_in,
  input logic [OVFN-1:0] stat_ovf,
  input logic            stat_oos,
  input logic [CNTW-1:0] cnt_idmis,
  input logic [CNTW-1:0] cnt_rot
);
  logic took;
  assign took = hdr_ready[0] && hdr_valid[0];

  AST_READY_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|hdr_ready) |-> ((&hdr_valid) && (&hdr_ready))); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bx) && $stable(out_ev)
      && $stable(out_corrupt) && $stable(out_mask))); // R2
  AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (hdr_ready == '0)); // R1
  AST_MASK_REF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_mask[0]); // R3
  AST_MASK_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_mask != '0)) |-> out_corrupt); // R4
  AST_OOS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (took && stat_oos) |=> (out_valid && out_corrupt)); // R5
  AST_OOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_oos |=> stat_oos); // R5
  AST_IDMIS_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_idmis >= $past(cnt_idmis))); // R6
  AST_ROT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_rot >= $past(cnt_rot))); // R7
  AST_OVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_in) |=> ((stat_ovf & $past(ovf_in)) == $past(ovf_in))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_ovf & $past(stat_ovf)) == $past(stat_ovf))); // R8
endmodule

bind evt_merge_check emc_checker #(
  .NSRC(NSRC), .BXW(BXW), .EVW(EVW), .OVFN(OVFN), .CNTW(CNTW)
) u_emc_checker (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bx(out_bx), .out_ev(out_ev),
  .out_corrupt(out_corrupt), .out_mask(out_mask), .ovf_in(ovf_in),
  .stat_ovf(stat_ovf), .stat_oos(stat_oos), .cnt_idmis(cnt_idmis), .cnt_rot(cnt_rot)
);

// File: tb/evt_merge_check_test.sv
`timescale 1ns/1ps
module evt_merge_check_test;
  localparam int NSRC = 3;
  localparam int BXW  = 12;
  localparam int EVW  = 24;
  localparam int OVFN = 2;
  localparam int CNTW = 4;
  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NSRC-1:0]     hdr_valid = '0;
  logic [NSRC-1:0]     hdr_ready;
  logic [NSRC*BXW-1:0] hdr_bx = '0;
  logic [NSRC*EVW-1:0] hdr_ev = '0;
  logic                out_valid;
  logic                out_ready = 1'b0;
  logic [BXW-1:0]      out_bx;
  logic [EVW-1:0]      out_ev;
  logic                out_corrupt;
  logic [NSRC-1:0]     out_mask;
  logic                rot_valid = 1'b0;
  logic [1:0]          rot_lsb = '0;
  logic [OVFN-1:0]     ovf_in = '0;
  logic [OVFN-1:0]     stat_ovf;
  logic                stat_oos;
  logic [CNTW-1:0]     cnt_idmis;
  logic [CNTW-1:0]     cnt_rot;

  always #10 clk = ~clk; // 50 MHz

  evt_merge_check #(.NSRC(NSRC), .BXW(BXW), .EVW(EVW), .OVFN(OVFN), .CNTW(CNTW)) uut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_bx(hdr_bx), .hdr_ev(hdr_ev), .out_valid(out_valid), .out_ready(out_ready),
    .out_bx(out_bx), .out_ev(out_ev), .out_corrupt(out_corrupt), .out_mask(out_mask),
    .rot_valid(rot_valid), .rot_lsb(rot_lsb), .ovf_in(ovf_in), .stat_ovf(stat_ovf),
    .stat_oos(stat_oos), .cnt_idmis(cnt_idmis), .cnt_rot(cnt_rot)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // ---- reference model state ----
  logic            m_ovalid, m_ocorrupt, m_oos;
  logic [BXW-1:0]  m_obx;
  logic [EVW-1:0]  m_oev;
  logic [NSRC-1:0] m_omask;
  logic [OVFN-1:0] m_ovf;
  logic [CNTW-1:0] m_cid, m_crot;
  logic [1:0]      m_last;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NSRC-1:0] exp_mask(input logic [NSRC*BXW-1:0] bx,
                                                input logic [NSRC*EVW-1:0] ev);
    logic [NSRC-1:0] m = '0;
    for (int i = 1; i < NSRC; i++)
      m[i] = (bx[i*BXW +: BXW] != bx[BXW-1:0]) || (ev[i*EVW +: EVW] != ev[EVW-1:0]);
    return m;
  endfunction

  function automatic logic [CNTW-1:0] sat_inc(input logic [CNTW-1:0] c, input logic en);
    return (en && c != CMAX) ? c + 1'b1 : c;
  endfunction

  function automatic logic exp_take(input logic [NSRC-1:0] v, input logic ov, input logic rdy);
    return (&v) && (!ov || rdy);
  endfunction

  task automatic model_reset();
    m_ovalid = 0; m_ocorrupt = 0; m_oos = 0; m_obx = '0; m_oev = '0;
    m_omask = '0; m_ovf = '0; m_cid = '0; m_crot = '0; m_last = '0;
  endtask

  task automatic check_outputs();
    chk("R2 out_valid", out_valid, m_ovalid);
    if (m_ovalid) begin
      chk("R2 out_bx", out_bx, m_obx);
      chk("R2 out_ev", out_ev, m_oev);
      chk("R3 out_mask", out_mask, m_omask);
      chk("R4 out_corrupt", out_corrupt, m_ocorrupt);
    end
    chk("R5 stat_oos", stat_oos, m_oos);
    chk("R8 stat_ovf", stat_ovf, m_ovf);
    chk("R6 cnt_idmis", cnt_idmis, m_cid);
    chk("R7 cnt_rot", cnt_rot, m_crot);
  endtask

  // Called after inputs are set for a cycle; advances the model over the next edge.
  task automatic model_step();
    logic take;
    logic [NSRC-1:0] mk;
    logic [1:0] rref;
    take = exp_take(hdr_valid, m_ovalid, out_ready);
    mk   = exp_mask(hdr_bx, hdr_ev);
    chk("R1 hdr_ready", hdr_ready, {NSRC{take}});
    rref = take ? hdr_ev[1:0] : m_last;
    m_crot = sat_inc(m_crot, rot_valid && (rot_lsb != rref));
    if (take) begin
      m_ocorrupt = (mk != '0) || m_oos || (m_ovf != '0);
      m_obx = hdr_bx[BXW-1:0];
      m_oev = hdr_ev[EVW-1:0];
      m_omask = mk;
      m_ovalid = 1'b1;
      m_last = hdr_ev[1:0];
      m_cid = sat_inc(m_cid, mk != '0);
      if (mk != '0) m_oos = 1'b1;
    end else if (out_ready) begin
      m_ovalid = 1'b0;
    end
    m_ovf = m_ovf | ovf_in;
  endtask

  task automatic set_headers(input int err_pct);
    logic [BXW-1:0] b = BXW'($urandom);
    logic [EVW-1:0] e = EVW'($urandom);
    for (int i = 0; i < NSRC; i++) begin
      hdr_bx[i*BXW +: BXW] = b;
      hdr_ev[i*EVW +: EVW] = e;
    end
    if (($urandom % 100) < err_pct) begin
      int s = 1 + ($urandom % (NSRC - 1));
      if ($urandom % 2) hdr_bx[s*BXW + BXW - 1] = ~hdr_bx[s*BXW + BXW - 1];
      else              hdr_ev[s*EVW + EVW - 1] = ~hdr_ev[s*EVW + EVW - 1];
    end
  endtask

  // One cycle: entered at a negedge, leaves at the next negedge.
  task automatic rand_cycle(input int vpct, input int epct, input int rpct, input int rotpct);
    check_outputs();
    for (int i = 0; i < NSRC; i++) hdr_valid[i] = (($urandom % 100) < vpct);
    set_headers(epct);
    out_ready = (($urandom % 100) < rpct);
    rot_valid = (($urandom % 100) < rotpct);
    rot_lsb   = 2'($urandom);
    ovf_in    = '0;
    #1 model_step();
    @(negedge clk);
  endtask

  task automatic idle_cycle();
    check_outputs();
    hdr_valid = '0; rot_valid = 0; ovf_in = '0; out_ready = 1'b1;
    #1 model_step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hdr_valid = '0; rot_valid = 0; ovf_in = '0; out_ready = 0;
    model_reset();
    repeat (2) @(negedge clk);
    // R9: everything cleared while reset is held
    chk("R9 out_valid clear", out_valid, 1'b0);
    chk("R9 stat_oos clear", stat_oos, 1'b0);
    chk("R9 stat_ovf clear", stat_ovf, '0);
    chk("R9 cnt_idmis clear", cnt_idmis, '0);
    chk("R9 cnt_rot clear", cnt_rot, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    @(negedge clk);
    do_reset();

    // R7: broadcast before any event compares against 0
    check_outputs();
    rot_valid = 1; rot_lsb = 2'd0; out_ready = 1;
    #1 model_step(); @(negedge clk);
    check_outputs();
    rot_lsb = 2'd3;
    #1 model_step(); @(negedge clk);
    chk("R7 rot vs zero ref", cnt_rot, 1);

    // Clean random traffic with back-pressure
    for (int n = 0; n < 300; n++) rand_cycle(85, 0, 60, 30);
    chk("R5 clean run no oos", stat_oos, 1'b0);
    idle_cycle();

    // Directed: R2 stall with the stage full, then a mismatch on the last source
    check_outputs();
    hdr_valid = '1; set_headers(0); out_ready = 0; rot_valid = 0;
    hdr_bx[(NSRC-1)*BXW] = ~hdr_bx[(NSRC-1)*BXW];
    #1 model_step(); @(negedge clk);
    chk("R3 last source mask", out_mask, 3'b100);
    chk("R4 mismatch corrupt", out_corrupt, 1'b1);
    chk("R5 oos set", stat_oos, 1'b1);
    check_outputs();
    hdr_valid = '1; set_headers(0);
    #1 chk("R1 stalled no ready", hdr_ready, '0);
    model_step(); @(negedge clk);
    chk("R2 held while stalled", out_mask, 3'b100);
    check_outputs();
    out_ready = 1;
    #1 model_step(); @(negedge clk);
    chk("R5 clean event after mismatch still corrupt", out_corrupt, 1'b1);
    chk("R3 clean event mask", out_mask, '0);

    // Error-heavy random run: drives both counters to saturation
    for (int n = 0; n < 400; n++) rand_cycle(90, 50, 70, 60);
    chk("R6 idmis saturated", cnt_idmis, CMAX);
    chk("R7 rot saturated", cnt_rot, CMAX);

    // R8 overflow after reset, one flag at a time
    do_reset();
    check_outputs();
    ovf_in = 2'b10; out_ready = 1;
    #1 model_step(); @(negedge clk);
    chk("R8 ovf bit1 latched", stat_ovf, 2'b10);
    check_outputs();
    ovf_in = '0; hdr_valid = '1; set_headers(0);
    #1 model_step(); @(negedge clk);
    chk("R4 ovf tags clean event", out_corrupt, 1'b1);
    chk("R8 ovf held", stat_ovf, 2'b10);
    chk("R5 ovf does not set oos", stat_oos, 1'b0);

    // R9 and clean traffic after reset
    do_reset();
    for (int n = 0; n < 150; n++) rand_cycle(80, 0, 80, 20);
    check_outputs();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule